// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-clock static RAM built for simulation and synthesis. Its inputs are registered and its read data is registered, so the memory runs as a pipeline. The array holds words of 18 bits, and each word is split into two 9-bit byte lanes. The depth is set by a parameter and is 256 words by default. The shared data bus is modelled as three signals: a write-data input, a read-data output and an output-enable flag.

An access starts on a load cycle, and only if all three chip selects are active. A load latches a base address. Each advance cycle after it moves a 2-bit burst counter on by one, and the counter wraps after four steps. The order input picks one of two burst sequences:

- interleaved: the low address bits are XORed with the count;
- linear: the count is added to the low address bits, modulo 4.

A write is decided on each access cycle. Global write stores both lanes. Byte write stores only the lanes whose enable is active. An access that enables no lane is a read.

A sleep input freezes the whole block and keeps all of its contents. The output enable is asynchronous and only gates the data-valid flag.

Top module: `psram_top`

## Requirements
- R1: In the cycle after a synchronous reset, `dout_en` is low whatever `oe_n` is, and no burst is active.
- R2: A read accepted at rising edge k (selected load, or advance inside an active burst, with no lane enabled) presents the addressed word on `dout` after edge k+1, with `dout_en` high when `oe_n` is low.
- R3: When `gw_n` is low on an access cycle, both lanes (bits 8:0 = lane 0, bits 17:9 = lane 1) are written from `din`, whatever `bwe_n` and `be_n` are.
- R4: When `gw_n` is high and `bwe_n` is low, only the lanes whose `be_n` bit is 0 are written. If `gw_n` and `bwe_n` are both high, or no lane is enabled, the access is a read.
- R5: A load is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. A load with any other chip-select value deselects the block, and after the edge that follows, `dout_en` is low.
- R6: With `mode`=1, advance step n (n = 1..3, wrapping after 4) accesses the base address with its two low bits XORed with n.
- R7: With `mode`=0, advance step n accesses the base address with its two low bits replaced by (low bits + n) mod 4. The upper address bits stay fixed.
- R8: An advance with no active burst (after reset or after a deselecting load) makes no access, and `dout_en` stays low one cycle later.
- R9: While `zz` is high, all inputs are ignored, `dout_en` is low, and the array, the burst state and any pending pipeline stage are kept. These resume when `zz` falls.
- R10: `oe_n` high forces `dout_en` low combinationally. It leaves `dout` and all internal state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address latched on a load |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld | input | 1 | Load a new base address and start an access |
| adv | input | 1 | Advance the burst counter and access the next word |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| be_n | input | 2 | Per-lane byte enables, active low |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep request, active high |
| din | input | 18 | Write data, taken on the access cycle |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | Read data is valid and is to be driven |

## Verification
A read accepted at one rising edge is due after the next edge. The bench therefore checks the output once per clock, just after each edge, against the value it predicted for the access it issued one cycle earlier. A write occupies the same slot with `dout_en` low, so deselect and write cycles are checked by that same one-cycle rule. Sleep cycles do not advance this prediction: each is checked only for a low `dout_en`, and the held prediction is checked after the first edge with `zz` low. The `oe_n` gate is sampled in the same cycle it is driven, because it involves no register.

// File: rtl/psram_pkg.sv
package psram_pkg;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;
    localparam int CNT_W  = 2;

    typedef logic [CNT_W-1:0]  bcnt_t;
    typedef logic [LANES-1:0]  lanes_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        logic   acc;
        logic   wr;
        lanes_t lanes;
    } req_t;

    function automatic bcnt_t burst_low(input bcnt_t base, input bcnt_t step, input order_e ord);
        bcnt_t r;
        if (ord == ORD_INTERLEAVE) r = base ^ step;
        else                       r = base + step;
        return r;
    endfunction
endpackage

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          ld,
    input  logic          sel,
    input  logic          adv,
    input  logic [AW-1:0] addr_i,
    input  logic          mode,
    output logic          acc_o,
    output logic [AW-1:0] addr_o
);
    logic          active;
    logic [AW-1:0] base;
    bcnt_t         cnt;
    bcnt_t         cnt_nx;
    order_e        ord;

    assign ord    = order_e'(mode);
    assign cnt_nx = cnt + bcnt_t'(1);

    always_comb begin
        acc_o = 1'b0;
        addr_o = addr_i;
        if (!hold) begin
            if (ld) begin
                acc_o = sel;
            end else if (adv && active) begin
                acc_o = 1'b1;
                addr_o = {base[AW-1:CNT_W], burst_low(base[CNT_W-1:0], cnt_nx, ord)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            base   <= '0;
            cnt    <= '0;
        end else if (!hold) begin
            if (ld) begin
                active <= sel;
                base   <= addr_i;
                cnt    <= '0;
            end else if (adv && active) begin
                cnt <= cnt_nx;
            end
        end
    end

    // R8
    idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !ld && adv && !active) |=> ($stable(cnt) && !active));

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !ld && adv && active) |=> (cnt == $past(cnt) + bcnt_t'(1)));

    // R9
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(cnt) && $stable(base) && $stable(active)));
endmodule

// File: rtl/psram_wdec.sv
module psram_wdec
    import psram_pkg::*;
(
    input  logic   gw_n,
    input  logic   bwe_n,
    input  lanes_t be_n,
    output lanes_t lanes
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lanes[l] = !gw_n || (!bwe_n && !be_n[l]);
    end
endmodule

// File: rtl/psram_array.sv
module psram_array
    import psram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  lanes_t        lanes,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we && lanes[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            if (re) rd_q <= mem[raddr];
        end

        assign rdata[l*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/psram_top.sv
module psram_top
    import psram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              ld,
    input  logic              adv,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  be_n,
    input  logic              mode,
    input  logic              oe_n,
    input  logic              zz,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout,
    output logic              dout_en
);
    logic          sel;
    logic          acc;
    logic [AW-1:0] acc_addr;
    lanes_t        lanes;
    req_t          req_q;
    logic [AW-1:0] addr_q;
    word_t         din_q;
    logic          vld_q;
    word_t         rdata;

    assign sel = !cs1_n && cs2 && !cs3_n;

    psram_burst #(.AW(AW)) u_burst (
        .clk(clk), .rst(rst), .hold(zz), .ld(ld), .sel(sel), .adv(adv),
        .addr_i(addr), .mode(mode), .acc_o(acc), .addr_o(acc_addr)
    );

    psram_wdec u_wdec (
        .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .lanes(lanes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            addr_q <= '0;
            din_q  <= '0;
        end else if (!zz) begin
            req_q.acc   <= acc;
            req_q.wr    <= acc && (lanes != '0);
            req_q.lanes <= lanes;
            addr_q      <= acc_addr;
            din_q       <= din;
        end
    end

    psram_array #(.AW(AW)) u_array (
        .clk(clk), .we(req_q.wr && !zz), .lanes(req_q.lanes), .waddr(addr_q),
        .wdata(din_q), .re(req_q.acc && !req_q.wr && !zz), .raddr(addr_q),
        .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)      vld_q <= 1'b0;
        else if (!zz) vld_q <= req_q.acc && !req_q.wr;
    end

    assign dout    = rdata;
    assign dout_en = vld_q && !oe_n && !zz;

    // R1
    rst_clear_chk: assert property (@(posedge clk) $past(rst) |-> !vld_q);

    // R5
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (!zz && !req_q.acc) |=> !vld_q);

    // R4
    wr_lane_chk: assert property (@(posedge clk) disable iff (rst)
        req_q.wr |-> (req_q.lanes != '0));

    // R9
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        zz |=> ($stable(vld_q) && $stable(dout) && $stable(req_q) && $stable(addr_q)));

    // R10
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_en);
endmodule

// File: tb/tb_psram_top.sv
`timescale 1ns/1ps
module tb_psram_top;
    localparam int AW = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic ld = 1'b0, adv = 1'b0, gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0] be_n = 2'b11;
    logic mode = 1'b0, oe_n = 1'b0, zz = 1'b0;
    logic [17:0] din = '0;
    logic [17:0] dout;
    logic dout_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    logic [17:0] ref_mem [DEPTH];
    bit          m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]  m_cnt = '0;
    bit          e_vld = 0;
    logic [17:0] e_data = '0;

    localparam logic [2:0] SEL = 3'b010;

    always #2.5 clk = ~clk;

    psram_top #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .ld(ld), .adv(adv), .gw_n(gw_n), .bwe_n(bwe_n), .be_n(be_n), .mode(mode),
        .oe_n(oe_n), .zz(zz), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [1:0] seq_low(logic [1:0] b, logic [1:0] n, logic m);
        if (m) return b ^ n;
        return 2'((b + n) % 4);
    endfunction

    task automatic check(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic [2:0] cs, bit l, bit a, bit g, bit bw, logic [1:0] be,
                        bit m, bit o, bit z, logic [AW-1:0] ad, logic [17:0] d, string tag);
        bit acc = 0;
        logic [AW-1:0] ea = ad;
        logic [1:0] ln = 2'b00;
        bit n_vld = e_vld;
        logic [17:0] n_data = e_data;
        bit s = (cs == SEL);
        if (!z) begin
            if (l) begin
                acc = s; m_act = s; m_base = ad; m_cnt = 0;
            end else if (a && m_act) begin
                m_cnt = m_cnt + 1;
                ea = {m_base[AW-1:2], seq_low(m_base[1:0], m_cnt, m)};
                acc = 1;
            end
            if (!g) ln = 2'b11;
            else if (!bw) ln = ~be;
            if (acc && ln != 0) begin
                if (ln[0]) ref_mem[ea][8:0] = d[8:0];
                if (ln[1]) ref_mem[ea][17:9] = d[17:9];
            end
            n_vld = acc && (ln == 0);
            n_data = ref_mem[ea];
        end
        {cs1_n, cs2, cs3_n} = cs;
        ld = l; adv = a; gw_n = g; bwe_n = bw; be_n = be; mode = m;
        oe_n = o; zz = z; addr = ad; din = d;
        @(posedge clk);
        #1;
        if (z) begin
            check(dout_en == 1'b0, {tag, "/R9 sleep"}, 18'(dout_en), 18'd0);
        end else begin
            check(dout_en == (e_vld && !o), tag, 18'(dout_en), 18'(e_vld && !o));
            if (e_vld) check(dout == e_data, tag, dout, e_data);
            e_vld = n_vld;
            e_data = n_data;
        end
    endtask

    task automatic wr(logic [AW-1:0] ad, logic [17:0] d, string tag);
        step(SEL, 1, 0, 0, 1, 2'b11, 0, 0, 0, ad, d, tag);
    endtask
    task automatic rd(logic [AW-1:0] ad, string tag);
        step(SEL, 1, 0, 1, 1, 2'b11, 0, 0, 0, ad, '0, tag);
    endtask
    task automatic idle(string tag);
        step(SEL, 0, 0, 1, 1, 2'b11, 0, 0, 0, '0, '0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        oe_n = 1'b0;
        check(dout_en == 1'b0, "R1 reset", 18'(dout_en), 18'd0);
        // R8: advance straight after reset is ignored
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 0, '0, '0, "R8 adv after reset");
        idle("R8 adv after reset");
        // R3: fill every word with a global write
        for (int i = 0; i < DEPTH; i++) wr(AW'(i), 18'(i * 1031 + 7), "R3 fill");
        for (int i = 0; i < 8; i++) rd(AW'(i * 29), "R2 read back");
        // R3: global write ignores lane enables
        step(SEL, 1, 0, 0, 0, 2'b10, 0, 0, 0, 8'h10, 18'h2AB55, "R3 global");
        rd(8'h10, "R3 global");
        // R4: byte writes, lane 0 then lane 1
        step(SEL, 1, 0, 1, 0, 2'b10, 0, 0, 0, 8'h11, 18'h3FFFF, "R4 lane0");
        step(SEL, 1, 0, 1, 0, 2'b01, 0, 0, 0, 8'h12, 18'h00000, "R4 lane1");
        // R4: no lanes enabled -> read
        step(SEL, 1, 0, 1, 0, 2'b11, 0, 0, 0, 8'h11, 18'h12345, "R4 no lane");
        rd(8'h12, "R4 lane1");
        // R6: interleaved burst from 0x21
        rd(8'h21, "R6 interleave");
        for (int i = 0; i < 4; i++) step(SEL, 0, 1, 1, 1, 2'b11, 1, 0, 0, '0, '0, "R6 interleave");
        // R7: linear burst from 0x46 with a write beat
        rd(8'h46, "R7 linear");
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 0, '0, '0, "R7 linear");
        step(SEL, 0, 1, 0, 1, 2'b11, 0, 0, 0, '0, 18'h1F0F0, "R7 linear write");
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 0, '0, '0, "R7 linear");
        rd(8'h44, "R7 linear");
        // R5: each inactive chip select deselects; R8 advance after it ignored
        rd(8'h30, "R5 pre");
        step(3'b110, 1, 0, 1, 1, 2'b11, 0, 0, 0, 8'h31, '0, "R5 cs1_n");
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 0, '0, '0, "R8 adv after deselect");
        rd(8'h30, "R5 pre");
        step(3'b000, 1, 0, 1, 1, 2'b11, 0, 0, 0, 8'h31, '0, "R5 cs2");
        rd(8'h30, "R5 pre");
        step(3'b011, 1, 0, 1, 1, 2'b11, 0, 0, 0, 8'h31, '0, "R5 cs3_n");
        idle("R5 after");
        // R10: oe_n high masks valid data without disturbing it
        rd(8'h50, "R10 pre");
        step(SEL, 0, 0, 1, 1, 2'b11, 0, 1, 0, '0, '0, "R10 oe off");
        // R9: sleep with a pending read and an active burst
        rd(8'h60, "R9 pre");
        step(SEL, 1, 0, 0, 1, 2'b11, 0, 0, 1, 8'h60, 18'h0, "R9 ignored write");
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 1, '0, '0, "R9 ignored adv");
        step(SEL, 0, 1, 1, 1, 2'b11, 0, 0, 0, '0, '0, "R9 resume");
        rd(8'h60, "R9 contents kept");
        idle("R9 after");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] cs = ($urandom % 4 == 0) ? 3'($urandom) : SEL;
            bit l = ($urandom % 3 == 0);
            bit a = ($urandom % 4 != 0);
            bit g = ($urandom % 5 != 0);
            bit bw = ($urandom % 3 != 0);
            step(cs, l, a, g, bw, 2'($urandom), 1'($urandom), ($urandom % 6 == 0),
                 ($urandom % 12 == 0), AW'($urandom), 18'($urandom), "R2 random mix");
        end
        idle("R2 drain");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule